// File: doc/BRIEF.md
# Masked Ready/Busy Aggregator for a Multi-Device Flash Card

This block folds the busy lines of up to twenty flash devices into one card-level ready signal. The same ready value is also visible to software as a status bit. Software reaches the block through a byte-wide register port with separate write and read addresses. The registers are:

- a busy status register that shows the true state of every device;
- a mask register that makes selected devices count as ready;
- a card status register that mirrors the ready pin;
- a mode register holding a mode select and a ready-acknowledge flag.

In standard mode the pin goes high only when no unmasked device is busy. In per-device completion mode the pin goes high once for each unmasked device that finishes, and then holds. Software acknowledges the event by clearing the acknowledge flag, which drops the pin and arms it for the next completion. Completions that arrive while the flag is still set are remembered and released one at a time, lowest device index first. Switching into this mode takes two separate writes to the mode register, so that the pin never shows a false first busy-to-ready edge.

Top module: `rdybsy_aggregator`

## Requirements
- R1: The busy status bytes at addresses 0, 1 and 2 show the device busy inputs (1 = busy) one clock after they are sampled. Device n is bit n%8 of byte n/8. The mask never changes these bytes, and absent devices read 0.
- R2: The mask bytes at addresses 4, 5 and 6 use the same bit layout as the busy bytes. They reset to all zero (unmasked). A device whose mask bit is 1 counts as ready for both the pin and the card status bit.
- R3: With NUM_DEV below 20, the mask bits of absent devices 19 down to NUM_DEV always read 1, and writes to them have no effect. Bits 7:4 of the mask byte at address 6 read 0.
- R4: In standard mode, card_ready is 1 exactly when no unmasked device was busy in the previous sample.
- R5: Bit 0 of the card status register at address 8 always equals card_ready.
- R6: The mode register is at address 12. Bit 0 is the mode select (0 = standard, 1 = per-device completion) and bit 1 is the acknowledge flag. Bits 7:2 read 0. Reset gives the value 0x02.
- R7: A mode-register write made while in standard mode loads only the mode select. Bit 1 of the written data is ignored, the acknowledge flag stays 1, and card_ready is 1 right after entry.
- R8: In per-device completion mode, card_ready equals the acknowledge flag. A write of 0x01 clears the flag, so card_ready is 0 after that clock edge.
- R9: In per-device completion mode with the flag clear, an unmasked device going from busy to idle sets the flag two clocks after the input falls. Completions of masked devices are ignored.
- R10: A completion that cannot be reported at once is held pending. This covers a completion that arrives while the flag is set, and every completion beyond the first when several arrive together. Each pending completion produces its own rise of card_ready one clock after the flag is cleared, lowest device index first.
- R11: A mode-register write with bit 0 = 0 returns the block to standard mode. It sets the flag and discards all pending completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_busy | input | NUM_DEV | Per-device busy, 1 = busy |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| card_ready | output | 1 | Card ready pin, 1 = ready |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:

- **Entry write with bit 1 = 0.** It writes 0x01 while still in standard mode. A design that let that write clear the flag would drop the pin at once.
- **Two simultaneous completions.** A design that merged them would rise only once, so the bench clears the flag twice and expects a second rise before a quiet pin.
- **Masked device finishing.** A design that leaked its completion would raise the pin.
- **Absent and reserved bits.** The bench reads these back after writing zeros to them. A design with a mis-padded map would then show wrong values.

// File: rtl/rdybsy_aggregator.sv
module rdybsy_aggregator #(
  parameter int NUM_DEV = 20,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_busy,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               card_ready
);
  localparam int MAX_DEV = 20;
  localparam int NBYTE   = (MAX_DEV + 7) / 8;
  localparam int PAD     = NBYTE * 8;
  localparam int A_BUSY  = 0;
  localparam int A_MASK  = 4;
  localparam int A_CSTAT = 8;
  localparam int A_MODE  = 12;

  logic [NUM_DEV-1:0] busy_q, busy_d, mask_q, pend_q;
  logic               mode_q, rack_q;
  logic [NUM_DEV-1:0] done_v, cand, first;
  logic [PAD-1:0]     busy_pad, mask_pad;
  logic               std_ready, fire, mode_wr, leave_hp;

  assign done_v    = busy_d & ~busy_q & ~mask_q;
  assign cand      = (pend_q | done_v) & ~mask_q;
  assign first     = cand & (~cand + 1'b1);
  assign fire      = mode_q & ~rack_q & (|cand);
  assign std_ready = ~|(busy_q & ~mask_q);
  assign mode_wr   = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign leave_hp  = mode_wr && !wr_data[0];
  assign card_ready = mode_q ? rack_q : std_ready;

  genvar g;
  generate
    for (g = 0; g < PAD; g++) begin : g_pad
      if (g < NUM_DEV) begin : g_real
        assign busy_pad[g] = busy_q[g];
        assign mask_pad[g] = mask_q[g];
      end else begin : g_absent
        assign busy_pad[g] = 1'b0;
        assign mask_pad[g] = (g < MAX_DEV);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      busy_d <= '0;
    end else begin
      busy_q <= dev_busy;
      busy_d <= busy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      for (int i = 0; i < NUM_DEV; i++)
        if (wr_en && wr_addr == ADDR_W'(A_MASK + i / 8))
          mask_q[i] <= wr_data[i % 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rack_q <= 1'b1;
      pend_q <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= wr_data[0];
        if (!wr_data[0])  rack_q <= 1'b1;
        else if (mode_q)  rack_q <= wr_data[1];
      end
      if (fire) rack_q <= 1'b1;

      if (!mode_q || leave_hp) pend_q <= '0;
      else if (fire)           pend_q <= cand & ~first;
      else                     pend_q <= cand;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < NBYTE; b++) begin
      if (rd_addr == ADDR_W'(A_BUSY + b)) rd_data = busy_pad[b*8 +: 8];
      if (rd_addr == ADDR_W'(A_MASK + b)) rd_data = mask_pad[b*8 +: 8];
    end
    if (rd_addr == ADDR_W'(A_CSTAT)) rd_data = {7'b0, card_ready};
    if (rd_addr == ADDR_W'(A_MODE))  rd_data = {6'b0, rack_q, mode_q};
  end
endmodule

module rdybsy_aggregator_chk #(
  parameter int NUM_DEV = 20,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_q,
  input logic               rack_q,
  input logic [NUM_DEV-1:0] pend_q,
  input logic               card_ready,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [1:0]         wr_lo,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [5:0]         rd_hi
);
  localparam int A_MODE = 12;
  logic mw;
  assign mw = wr_en && (wr_addr == ADDR_W'(A_MODE));

  // R11
  std_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (rack_q && pend_q == '0));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw && !mode_q && wr_lo[0]) |=> (rack_q && card_ready));

  // R8
  rack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw && mode_q && rack_q && wr_lo == 2'b01) |=> !card_ready);

  // R10
  rack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && rack_q && !mw) |=> rack_q);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(A_MODE)) |-> (rd_hi == 6'b0));
endmodule

bind rdybsy_aggregator rdybsy_aggregator_chk #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .rack_q(rack_q), .pend_q(pend_q),
  .card_ready(card_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lo(wr_data[1:0]),
  .rd_addr(rd_addr), .rd_hi(rd_data[7:2]));

// File: tb/rdybsy_aggregator_tb_top.sv
`timescale 1ns/10ps
module rdybsy_aggregator_tb_top;
  localparam int ND = 14;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND-1:0] dev_busy = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [3:0]    rd_addr;
  logic [7:0]    rd_data;
  logic          card_ready;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  typedef struct {
    bit         is_rd;
    logic [3:0] addr;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  rdybsy_aggregator #(.NUM_DEV(ND), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_busy(dev_busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .card_ready(card_ready));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic exp_pin(input logic v, input string tag);
    exp_t e;
    e.is_rd = 1'b0; e.addr = '0; e.val = {7'b0, v}; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [7:0] v, input string tag);
    exp_t e;
    e.is_rd = 1'b1; e.addr = a; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_busy(input logic [ND-1:0] v);
    dev_busy = v;
    step();
  endtask

  initial begin
    rd_addr = '0;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] got;
        e = q.pop_front();
        if (e.is_rd) begin
          rd_addr = e.addr;
          #0.2;
          got = rd_data;
        end else begin
          got = {7'b0, card_ready};
        end
        n_run++;
        if (got !== e.val) begin
          n_fail++;
          $display("FAIL %s: got %02h expected %02h", e.tag, got, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    exp_rd(4'd12, 8'h02, "R6 mode reset");
    exp_pin(1'b1, "R4 reset ready");
    exp_rd(4'd8, 8'h01, "R5 status reset");
    exp_rd(4'd4, 8'h00, "R2 mask reset");
    exp_rd(4'd5, 8'hC0, "R3 absent mask byte1");
    exp_rd(4'd6, 8'h0F, "R3 absent mask byte2");

    set_busy(14'h0005);
    exp_rd(4'd0, 8'h05, "R1 busy status");
    exp_pin(1'b0, "R4 busy unmasked");
    exp_rd(4'd8, 8'h00, "R5 status busy");

    wr(4'd4, 8'h05);
    exp_pin(1'b1, "R2 masked counts ready");
    exp_rd(4'd0, 8'h05, "R1 mask no effect on status");
    exp_rd(4'd4, 8'h05, "R2 mask readback");

    wr(4'd6, 8'h00);
    wr(4'd5, 8'h00);
    exp_rd(4'd6, 8'h0F, "R3 absent write ignored");
    exp_rd(4'd5, 8'hC0, "R3 absent write ignored b1");

    wr(4'd4, 8'h00);
    exp_pin(1'b0, "R4 unmasked busy");
    set_busy(14'h0004);
    exp_pin(1'b0, "R4 one still busy");
    set_busy(14'h0000);
    exp_pin(1'b1, "R4 all idle");

    wr(4'd4, 8'hFF);
    wr(4'd5, 8'hFF);
    wr(4'd12, 8'h01);
    exp_rd(4'd12, 8'h03, "R7 rack ignored on entry");
    exp_pin(1'b1, "R7 no spurious drop");
    wr(4'd12, 8'h01);
    exp_rd(4'd12, 8'h01, "R8 rack cleared");
    exp_pin(1'b0, "R8 pin low");

    set_busy(14'h0003);
    wr(4'd4, 8'hFC);
    exp_pin(1'b0, "R9 armed quiet");
    set_busy(14'h0002);
    exp_pin(1'b0, "R9 one cycle after fall");
    step();
    exp_pin(1'b1, "R9 completion raises pin");
    exp_rd(4'd12, 8'h03, "R9 rack set");
    exp_rd(4'd8, 8'h01, "R5 status mirrors pin");

    wr(4'd12, 8'h01);
    exp_pin(1'b0, "R8 re-arm");
    set_busy(14'h0006);
    set_busy(14'h0002);
    step();
    step();
    exp_pin(1'b0, "R9 masked completion ignored");

    wr(4'd4, 8'hE4);
    set_busy(14'h001A);
    step();
    exp_pin(1'b0, "R10 quiet before completions");
    set_busy(14'h0002);
    exp_pin(1'b0, "R10 one cycle after fall");
    step();
    exp_pin(1'b1, "R10 first of two");
    wr(4'd12, 8'h01);
    exp_pin(1'b0, "R10 cleared");
    step();
    exp_pin(1'b1, "R10 pending second rise");
    wr(4'd12, 8'h01);
    step();
    step();
    exp_pin(1'b0, "R10 no third rise");

    set_busy(14'h0000);
    exp_pin(1'b0, "R9 dev1 one cycle");
    step();
    exp_pin(1'b1, "R9 dev1 completion");

    set_busy(14'h0001);
    exp_pin(1'b1, "R8 pin follows rack");
    wr(4'd12, 8'h00);
    exp_rd(4'd12, 8'h02, "R11 back to standard");
    exp_pin(1'b0, "R11 standard rule applies");

    step();
    step();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule